// File: doc/BRIEF.md
# Key-locked watchdog enable register

This block is the register slice that arms a digital watchdog and records pending compare interrupts. A bus master arms the watchdog by writing one exact 32-bit key, with privileged access, to the control register. From then on the armed state is frozen. No later write of any value, privileged or not, can disarm it. Only a reset clears it. While disarmed, the control register reads back a fixed idle code. Once armed, it reads back the key.

A second register holds one pending flag per compare channel. A hardware event sets a flag. Software clears a flag by writing a 1 to its bit. The run output that drives the watchdog counter is the armed state, gated by a clock-source-valid input, so an unusable watchdog clock acts like a disarmed watchdog. Each interrupt output is its flag masked by a per-channel enable input. The counter itself lives outside this block.

Top module: `wdog_keylock_regs`

## Requirements
- R1: After reset, the control register (byte offset 0x90) reads 0x5312ACED, the flag register (byte offset 0x88) reads 0, `wd_run` is 0 and `wd_irq` is 0.
- R2: A privileged write of 0xA98559DA to offset 0x90 arms the watchdog. From the next cycle, offset 0x90 reads 0xA98559DA.
- R3: While disarmed, a write of any other 32-bit value to offset 0x90 leaves the block disarmed, and the register keeps reading 0x5312ACED.
- R4: A write to offset 0x90 with `bus_priv` low is dropped, even when it carries the arming key.
- R5: Once armed, every later write to offset 0x90, whatever its value or privilege, leaves the block armed and reading 0xA98559DA.
- R6: `wd_run` is 1 exactly when the block is armed and `clk_src_ok` is 1, in the same cycle.
- R7: A 1 on `cmp_evt[i]` in a cycle sets bit i of the flag register (bits 3:0). The flag reads 1 from the next cycle. Bits 31:4 always read 0.
- R8: A write to offset 0x88 clears each flag bit whose write-data bit is 1 and leaves each flag bit whose write-data bit is 0 unchanged, from the next cycle.
- R9: When `cmp_evt[i]` and a write-one-to-clear of bit i fall in the same cycle, the flag ends up set.
- R10: `wd_irq[i]` equals flag bit i AND `irq_en[i]`, in the same cycle.
- R11: A read of any offset other than 0x88 or 0x90 returns 0. A write to any such offset changes neither register.
- R12: A reset applied while the block is armed returns it to the disarmed state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_priv | input | 1 | Access is from a privileged master |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cmp_evt | input | 4 | Compare-match set pulses, one per channel |
| irq_en | input | 4 | Per-channel interrupt enable |
| clk_src_ok | input | 1 | Watchdog clock source is usable |
| wd_run | output | 1 | Watchdog counter enable |
| wd_irq | output | 4 | Per-channel interrupt requests |

## Verification
Register state changes at the clock edge on which a write or an event is sampled, so a new armed state or flag value is due one cycle later. Read data, `wd_run` and `wd_irq` are combinational views of that state and of the current inputs, so they are due in the same cycle as the address or enable that selects them. The bench drives each stimulus on a falling edge and compares all three outputs just after it, against a reference model. It advances the model only at the next rising edge, which places every registered result exactly one cycle after its cause.

// File: rtl/wdkl_pkg.sv
package wdkl_pkg;

  localparam int unsigned DATA_W = 32;

  // Control register codes
  localparam logic [DATA_W-1:0] ARM_KEY   = 32'hA985_59DA;
  localparam logic [DATA_W-1:0] IDLE_CODE = 32'h5312_ACED;

  // Decoded bus access
  typedef struct packed {
    logic ctrl_sel;
    logic flag_sel;
    logic ctrl_wr;
    logic flag_wr;
  } wdkl_dec_t;

endpackage

// File: rtl/wdkl_decode.sv
module wdkl_decode
  import wdkl_pkg::*;
#(
  parameter int unsigned           ADDR_W   = 12,
  parameter logic [ADDR_W-1:0]     CTRL_OFS = 12'h090,
  parameter logic [ADDR_W-1:0]     FLAG_OFS = 12'h088
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output wdkl_dec_t         dec
);

  always_comb begin
    dec          = '0;
    dec.ctrl_sel = (addr == CTRL_OFS);
    dec.flag_sel = (addr == FLAG_OFS);
    dec.ctrl_wr  = wr & dec.ctrl_sel;
    dec.flag_wr  = wr & dec.flag_sel;
  end

endmodule

// File: rtl/wdkl_enable_lock.sv
module wdkl_enable_lock
  import wdkl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              priv,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed
);

  logic armed_q;
  logic armed_d;
  logic take_key;

  // Next state: arm once on an exact privileged key, never disarm
  always_comb begin
    take_key = ctrl_wr & priv & ~armed_q & (wdata == ARM_KEY);
    armed_d  = armed_q | take_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (take_key) begin
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;

  // Armed state is sticky until reset
  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

  // Anything but a privileged key write leaves a disarmed block disarmed
  assert_no_arm_without_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !(ctrl_wr && wdata == ARM_KEY)) |=> !armed_q);

  assert_no_arm_unpriv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !priv) |=> !armed_q);

  assert_key_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && priv && wdata == ARM_KEY) |=> armed_q);

endmodule

// File: rtl/wdkl_flag_bank.sv
module wdkl_flag_bank #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_evt,
  input  logic           clr_wr,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] flags
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_flag
    logic flag_q;
    logic flag_d;
    logic clr_hit;
    logic flag_ce;

    // Set has priority over a same-cycle clear
    always_comb begin
      clr_hit = clr_wr & clr_mask[ch];
      flag_ce = set_evt[ch] | clr_hit;
      flag_d  = set_evt[ch] | (flag_q & ~clr_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (flag_ce) begin
        flag_q <= flag_d;
      end
    end

    assign flags[ch] = flag_q;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[ch] |=> flag_q);

    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && clr_wr && clr_mask[ch] && !set_evt[ch]) |=> !flag_q);

    assert_only_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !set_evt[ch]) |=> !flag_q);

    assert_zero_write_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(clr_wr && clr_mask[ch])) |=> flag_q);
  end

endmodule

// File: rtl/wdkl_read_mux.sv
module wdkl_read_mux
  import wdkl_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  wdkl_dec_t         dec,
  input  logic              armed,
  input  logic [NCH-1:0]    flags,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] flag_word;

  always_comb begin
    flag_word            = '0;
    flag_word[NCH-1:0]   = flags;
    if (dec.ctrl_sel) begin
      rdata = armed ? ARM_KEY : IDLE_CODE;
    end else if (dec.flag_sel) begin
      rdata = flag_word;
    end else begin
      rdata = '0;
    end
  end

endmodule

// File: rtl/wdog_keylock_regs.sv
module wdog_keylock_regs
  import wdkl_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 12,
  parameter int unsigned       NCH      = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h090,
  parameter logic [ADDR_W-1:0] FLAG_OFS = 12'h088
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_priv,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    cmp_evt,
  input  logic [NCH-1:0]    irq_en,
  input  logic              clk_src_ok,
  output logic              wd_run,
  output logic [NCH-1:0]    wd_irq
);

  wdkl_dec_t      dec;
  logic           armed;
  logic [NCH-1:0] flags;

  wdkl_decode #(
    .ADDR_W  (ADDR_W),
    .CTRL_OFS(CTRL_OFS),
    .FLAG_OFS(FLAG_OFS)
  ) u_decode (
    .addr(bus_addr),
    .wr  (bus_wr),
    .dec (dec)
  );

  wdkl_enable_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_wr(dec.ctrl_wr),
    .priv   (bus_priv),
    .wdata  (bus_wdata),
    .armed  (armed)
  );

  wdkl_flag_bank #(
    .NCH(NCH)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (cmp_evt),
    .clr_wr  (dec.flag_wr),
    .clr_mask(bus_wdata[NCH-1:0]),
    .flags   (flags)
  );

  wdkl_read_mux #(
    .NCH(NCH)
  ) u_rmux (
    .dec  (dec),
    .armed(armed),
    .flags(flags),
    .rdata(bus_rdata)
  );

  // Unusable clock source behaves like a disarmed watchdog
  always_comb begin
    wd_run = armed & clk_src_ok;
    wd_irq = flags & irq_en;
  end

  assert_run_needs_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_run |-> clk_src_ok);

  assert_run_matches_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src_ok && bus_addr == CTRL_OFS) |-> (wd_run == (bus_rdata == ARM_KEY)));

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_irq & ~irq_en) == '0);

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != CTRL_OFS && bus_addr != FLAG_OFS) |-> bus_rdata == '0);

  assert_ctrl_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTRL_OFS) |-> (bus_rdata == ARM_KEY || bus_rdata == IDLE_CODE));

endmodule

// File: tb/tb_wdog_keylock_regs.sv
module tb_wdog_keylock_regs;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h090;
  localparam logic [11:0] A_FLAG = 12'h088;
  localparam logic [31:0] K_ARM  = 32'hA985_59DA;
  localparam logic [31:0] K_IDLE = 32'h5312_ACED;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic        bus_priv;
  logic [31:0] bus_rdata;
  logic [3:0]  cmp_evt;
  logic [3:0]  irq_en;
  logic        clk_src_ok;
  logic        wd_run;
  logic [3:0]  wd_irq;

  // Reference model state
  bit       m_armed;
  bit [3:0] m_flags;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_keylock_regs dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_priv  (bus_priv),
    .bus_rdata (bus_rdata),
    .cmp_evt   (cmp_evt),
    .irq_en    (irq_en),
    .clk_src_ok(clk_src_ok),
    .wd_run    (wd_run),
    .wd_irq    (wd_irq)
  );

  task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive, compare combinational outputs, advance model at the edge
  task automatic cyc(string tag, logic [11:0] a, logic [31:0] d, logic w, logic p,
                     logic [3:0] e, logic ck, logic [3:0] ie);
    logic [31:0] exp_rd;
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_priv = p;
    cmp_evt = e; clk_src_ok = ck; irq_en = ie;
    #1;
    if (a == A_CTRL)      exp_rd = m_armed ? K_ARM : K_IDLE;
    else if (a == A_FLAG) exp_rd = {28'h0, m_flags};
    else                  exp_rd = 32'h0;
    check_eq(tag, "bus_rdata", bus_rdata, exp_rd);
    check_eq(tag, "wd_run", {31'h0, wd_run}, {31'h0, m_armed & ck});
    check_eq(tag, "wd_irq", {28'h0, wd_irq}, {28'h0, m_flags & ie});
    @(posedge clk);
    if (rst_n) begin
      if (w && p && a == A_CTRL && d == K_ARM) m_armed = 1'b1;
      if (w && a == A_FLAG) m_flags = m_flags & ~d[3:0];
      m_flags = m_flags | e;
    end
    @(negedge clk);
  endtask

  task automatic idle(string tag, logic [11:0] a, logic ck, logic [3:0] ie);
    cyc(tag, a, 32'h0, 1'b0, 1'b0, 4'h0, ck, ie);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_priv = 1'b0;
    cmp_evt = '0; irq_en = '0; clk_src_ok = 1'b1;
    m_armed = 1'b0; m_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    idle("R1", A_CTRL, 1'b1, 4'hF);
    idle("R1", A_FLAG, 1'b1, 4'hF);

    // R3: wrong values leave it disarmed
    cyc("R3", A_CTRL, K_IDLE,       1'b1, 1'b1, 4'h0, 1'b1, 4'h0);
    cyc("R3", A_CTRL, 32'hA985_59DB, 1'b1, 1'b1, 4'h0, 1'b1, 4'h0);
    cyc("R3", A_CTRL, 32'h0,         1'b1, 1'b1, 4'h0, 1'b1, 4'h0);
    idle("R3", A_CTRL, 1'b1, 4'h0);

    // R4: unprivileged key dropped
    cyc("R4", A_CTRL, K_ARM, 1'b1, 1'b0, 4'h0, 1'b1, 4'h0);
    idle("R4", A_CTRL, 1'b1, 4'h0);

    // R11: key at unmapped offsets, unmapped reads
    cyc("R11", 12'h094, K_ARM, 1'b1, 1'b1, 4'h0, 1'b1, 4'h0);
    cyc("R11", 12'h010, K_ARM, 1'b1, 1'b1, 4'h0, 1'b1, 4'h0);
    idle("R11", A_CTRL, 1'b1, 4'h0);

    // R7 / R10: events set flags, masked by enables
    cyc("R7", A_FLAG, 32'h0, 1'b0, 1'b0, 4'b0101, 1'b1, 4'h0);
    idle("R7", A_FLAG, 1'b1, 4'b0011);
    cyc("R7", A_FLAG, 32'h0, 1'b0, 1'b0, 4'b1010, 1'b1, 4'b1100);
    idle("R10", A_FLAG, 1'b1, 4'b1001);
    idle("R10", A_FLAG, 1'b1, 4'b0000);

    // R11: write-ones at unmapped offset leave flags
    cyc("R11", 12'h08C, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'h0, 1'b1, 4'hF);
    idle("R11", A_FLAG, 1'b1, 4'hF);

    // R8: write-one-to-clear, zeros keep
    cyc("R8", A_FLAG, 32'hFFFF_FF05, 1'b1, 1'b0, 4'h0, 1'b1, 4'hF);
    idle("R8", A_FLAG, 1'b1, 4'hF);
    cyc("R8", A_FLAG, 32'h0, 1'b1, 1'b1, 4'h0, 1'b1, 4'hF);
    idle("R8", A_FLAG, 1'b1, 4'hF);

    // R9: set beats same-cycle clear
    cyc("R9", A_FLAG, 32'hF, 1'b1, 1'b1, 4'b0010, 1'b1, 4'hF);
    idle("R9", A_FLAG, 1'b1, 4'hF);
    cyc("R9", A_FLAG, 32'hF, 1'b1, 1'b1, 4'b0000, 1'b1, 4'hF);
    idle("R9", A_FLAG, 1'b1, 4'hF);

    // R6: clock gating while disarmed
    idle("R6", A_CTRL, 1'b0, 4'h0);

    // R2: arm with the key
    cyc("R2", A_CTRL, K_ARM, 1'b1, 1'b1, 4'h0, 1'b1, 4'h0);
    idle("R2", A_CTRL, 1'b1, 4'h0);

    // R6: armed but clock source unusable
    idle("R6", A_CTRL, 1'b0, 4'h0);
    idle("R6", A_CTRL, 1'b1, 4'h0);

    // R5: later writes ignored
    cyc("R5", A_CTRL, K_IDLE, 1'b1, 1'b1, 4'h0, 1'b1, 4'h0);
    cyc("R5", A_CTRL, 32'h0,  1'b1, 1'b1, 4'h0, 1'b1, 4'h0);
    cyc("R5", A_CTRL, K_ARM,  1'b1, 1'b0, 4'h0, 1'b1, 4'h0);
    cyc("R5", A_CTRL, K_ARM,  1'b1, 1'b1, 4'h0, 1'b1, 4'h0);
    idle("R5", A_CTRL, 1'b1, 4'h0);

    // R12: reset while armed
    cyc("R12", A_FLAG, 32'h0, 1'b0, 1'b0, 4'b1000, 1'b1, 4'hF);
    rst_n = 1'b0;
    m_armed = 1'b0; m_flags = '0;
    idle("R12", A_CTRL, 1'b1, 4'hF);
    rst_n = 1'b1;
    idle("R12", A_CTRL, 1'b1, 4'hF);
    idle("R12", A_FLAG, 1'b1, 4'hF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule